// File: doc/BRIEF.md
# Thermistor Threshold Monitor

This block turns host-triggered temperature acquisitions into a stored reading and a small set of event flags. A start request launches one conversion on an external converter. The converter returns an 8-bit two's-complement temperature code in degrees Celsius. The block clamps the code to the supported range and stores it in a readable value register. It then compares the stored reading with a programmable hot threshold, a programmable cold threshold and a self-updating baseline.

The baseline is set by the first reading after wakeup or reset. Later readings replace it only when they move away from it by at least the programmed change threshold. Each such move raises a change event. The event flags are sticky. The host clears each flag with its own clear bit. Pulling the wakeup input low returns the block to its sleep state.

The converter result arrives on a valid/ready stream. `res_ready_o` is high only while an acquisition is running and wakeup is high. The converter must hold `res_valid_i` and `res_code_i` steady until a cycle in which both valid and ready are high. That cycle transfers the result. A result offered at any other time waits and is not consumed. The start request, the converter start pulse, the configuration fields and the status outputs are plain level or pulse signals.

Top module: `therm_watch`

## Requirements
- R1: With wakeup high and no acquisition running, a start request is accepted. On the next cycle the start bit reads 1, the conversion-done status reads 0, and `adc_start_o` is high for exactly that one cycle.
- R2: The conversion-done status reads 1 after reset and whenever no acquisition is running. In the cycle after a result is transferred, the start bit has cleared itself and the conversion-done status reads 1 again.
- R3: A start request made while an acquisition is running is ignored. It produces no further converter start pulse.
- R4: `res_ready_o` is 0 whenever no acquisition is running. A result offered then is not consumed and leaves the value register and the flags unchanged.
- R5: When a result is transferred, the clamped code is written to the value register and the end-of-conversion flag (`flags_o[0]`) is set.
- R6: Codes are clamped to the supported range. A signed code below -10 is reported as 0xF6, a code above 85 is reported as 0x55, and codes from -10 to 85 pass unchanged.
- R7: On a transfer, the hot flag (`flags_o[1]`) is set if the clamped reading is at or above 42 + `hot_sel_i`, with `hot_sel_i` taken as an unsigned number from 0 to 15.
- R8: On a transfer, the cold flag (`flags_o[2]`) is set if the clamped reading is at or below -7 + `cold_sel_i`, with `cold_sel_i` taken as an unsigned number from 0 to 15.
- R9: The first reading after reset, or after wakeup returns high, becomes the baseline. It does not set the change flag (`flags_o[3]`).
- R10: For a later reading, the block compares the magnitude of the reading minus the baseline with 2 + `dt_sel_i` degrees (2, 3, 4 or 5). If the magnitude is equal or greater, the change flag is set and the reading becomes the new baseline. Otherwise the flag is not set and the baseline is kept.
- R11: The flags are sticky. `flag_clr_i[k]` clears `flags_o[k]` on the next edge. If a flag is set and cleared on the same edge, the set wins.
- R12: While wakeup is low, the block returns to its reset state: no acquisition running, all flags 0, value register 0x00 and no baseline. Start requests are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wakeup; low holds the block in its sleep/reset state |
| start_i | input | 1 | Host start request (write of 1 to the start bit) |
| adc_start_o | output | 1 | One-cycle pulse that starts the external converter |
| res_valid_i | input | 1 | Converter result valid |
| res_ready_o | output | 1 | Block ready to take a result (acquisition running) |
| res_code_i | input | 8 | Two's-complement temperature code from the converter |
| dt_sel_i | input | 2 | Change threshold select, 2 + value degrees |
| hot_sel_i | input | 4 | Hot threshold select, 42 + value degrees |
| cold_sel_i | input | 4 | Cold threshold select, -7 + value degrees |
| flag_clr_i | input | 4 | Per-flag clear: bit0 end-of-conversion, bit1 hot, bit2 cold, bit3 change |
| start_bit_o | output | 1 | Start bit readback, 1 while an acquisition runs |
| conv_done_o | output | 1 | Conversion-done status, 0 while converting |
| temp_value_o | output | 8 | Last clamped temperature reading |
| flags_o | output | 4 | Sticky flags: bit0 end-of-conversion, bit1 hot, bit2 cold, bit3 change |

## Verification
The checker watches the acquisition handshake on every cycle. It confirms that an idle start request launches exactly one converter pulse and that requests during a conversion launch none. It confirms that ready stays low while idle, that the value register holds still without a transfer, and that the stored reading never leaves the clamped range. It also checks that a transfer clears the start bit and sets the end-of-conversion flag, and that wakeup low empties the block. The threshold arithmetic cannot be checked cycle by cycle. That covers the hot and cold bounds, the magnitude comparison against the baseline, the first-reading rule and baseline replacement. The bench covers it with sweeps over every input code and every threshold setting, and compares each result with a model computed in the bench.

// File: rtl/therm_watch_pkg.sv
package therm_watch_pkg;

  typedef enum logic {
    ACQ_IDLE = 1'b0,
    ACQ_RUN  = 1'b1
  } acq_state_t;

  // Flag vector; bit order is visible at the ports (bit0 eoc ... bit3 chg).
  typedef struct packed {
    logic chg;
    logic cold;
    logic hot;
    logic eoc;
  } tw_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(tw_flags_t);

endpackage

// File: rtl/therm_acq_ctrl.sv
module therm_acq_ctrl
  import therm_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic start_i,
  input  logic res_valid_i,
  output logic busy_o,
  output logic res_ready_o,
  output logic adc_start_o,
  output logic accept_o
);

  acq_state_t state_q;
  logic       pulse_q;
  logic       launch;

  assign launch      = wake_i && (state_q == ACQ_IDLE) && start_i;
  assign busy_o      = (state_q == ACQ_RUN);
  assign res_ready_o = busy_o && wake_i;
  assign accept_o    = res_valid_i && res_ready_o;
  assign adc_start_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACQ_IDLE;
      pulse_q <= 1'b0;
    end else if (!wake_i) begin
      state_q <= ACQ_IDLE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= launch;
      unique case (state_q)
        ACQ_IDLE: if (start_i)     state_q <= ACQ_RUN;
        ACQ_RUN:  if (res_valid_i) state_q <= ACQ_IDLE;
        default:                   state_q <= ACQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/therm_clamp.sv
module therm_clamp #(
  parameter int CODE_W   = 8,
  parameter int LO_LIMIT = -10,
  parameter int HI_LIMIT = 85
) (
  input  logic signed [CODE_W-1:0] code_i,
  output logic signed [CODE_W-1:0] code_o
);

  localparam logic signed [CODE_W-1:0] LO_C = CODE_W'(LO_LIMIT);
  localparam logic signed [CODE_W-1:0] HI_C = CODE_W'(HI_LIMIT);

  always_comb begin
    if (code_i < LO_C)      code_o = LO_C;
    else if (code_i > HI_C) code_o = HI_C;
    else                    code_o = code_i;
  end

endmodule

// File: rtl/therm_judge.sv
module therm_judge #(
  parameter int CODE_W    = 8,
  parameter int SEL_W     = 4,
  parameter int DT_W      = 2,
  parameter int HOT_BASE  = 42,
  parameter int COLD_BASE = -7,
  parameter int DT_BASE   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wake_i,
  input  logic                     accept_i,
  input  logic signed [CODE_W-1:0] sample_i,
  input  logic [SEL_W-1:0]         hot_sel_i,
  input  logic [SEL_W-1:0]         cold_sel_i,
  input  logic [DT_W-1:0]          dt_sel_i,
  output logic [CODE_W-1:0]        value_o,
  output logic                     hot_o,
  output logic                     cold_o,
  output logic                     chg_o
);

  // One extra bit keeps threshold sums and the difference free of overflow.
  localparam int XW = CODE_W + 1;
  localparam logic signed [XW-1:0] HOT_C  = XW'(HOT_BASE);
  localparam logic signed [XW-1:0] COLD_C = XW'(COLD_BASE);
  localparam logic        [XW-1:0] DT_C   = XW'(DT_BASE);

  logic [CODE_W-1:0]        value_q;
  logic signed [CODE_W-1:0] base_q;
  logic                     base_vld_q;

  logic signed [XW-1:0] samp_x, base_x, hot_thr, cold_thr, diff;
  logic        [XW-1:0] mag, dt_thr;

  always_comb begin
    samp_x   = {sample_i[CODE_W-1], sample_i};
    base_x   = {base_q[CODE_W-1], base_q};
    hot_thr  = HOT_C  + $signed({{(XW-SEL_W){1'b0}}, hot_sel_i});
    cold_thr = COLD_C + $signed({{(XW-SEL_W){1'b0}}, cold_sel_i});
    dt_thr   = DT_C   + {{(XW-DT_W){1'b0}}, dt_sel_i};
    diff     = samp_x - base_x;
    mag      = diff[XW-1] ? -diff : diff;
    hot_o    = (samp_x >= hot_thr);
    cold_o   = (samp_x <= cold_thr);
    chg_o    = base_vld_q && (mag >= dt_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q    <= '0;
      base_q     <= '0;
      base_vld_q <= 1'b0;
    end else if (!wake_i) begin
      value_q    <= '0;
      base_q     <= '0;
      base_vld_q <= 1'b0;
    end else if (accept_i) begin
      value_q <= sample_i;
      if (!base_vld_q || chg_o) begin
        base_q     <= sample_i;
        base_vld_q <= 1'b1;
      end
    end
  end

  assign value_o = value_q;

endmodule

// File: rtl/therm_flag_bank.sv
module therm_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wake_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q <= 1'b0;
      else if (!wake_i)   bit_q <= 1'b0;
      else if (set_i[i])  bit_q <= 1'b1;
      else if (clr_i[i])  bit_q <= 1'b0;
    end
    assign flag_o[i] = bit_q;
  end

endmodule

// File: rtl/therm_watch.sv
module therm_watch
  import therm_watch_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SEL_W     = 4,
  parameter int DT_W      = 2,
  parameter int LO_LIMIT  = -10,
  parameter int HI_LIMIT  = 85,
  parameter int HOT_BASE  = 42,
  parameter int COLD_BASE = -7,
  parameter int DT_BASE   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_i,
  input  logic                 start_i,
  output logic                 adc_start_o,
  input  logic                 res_valid_i,
  output logic                 res_ready_o,
  input  logic [CODE_W-1:0]    res_code_i,
  input  logic [DT_W-1:0]      dt_sel_i,
  input  logic [SEL_W-1:0]     hot_sel_i,
  input  logic [SEL_W-1:0]     cold_sel_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  output logic                 start_bit_o,
  output logic                 conv_done_o,
  output logic [CODE_W-1:0]    temp_value_o,
  output logic [NUM_FLAGS-1:0] flags_o
);

  logic                     busy, accept;
  logic signed [CODE_W-1:0] clamped;
  logic                     hot, cold, chg;
  tw_flags_t                set_v;

  therm_acq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_i      (wake_i),
    .start_i     (start_i),
    .res_valid_i (res_valid_i),
    .busy_o      (busy),
    .res_ready_o (res_ready_o),
    .adc_start_o (adc_start_o),
    .accept_o    (accept)
  );

  therm_clamp #(
    .CODE_W   (CODE_W),
    .LO_LIMIT (LO_LIMIT),
    .HI_LIMIT (HI_LIMIT)
  ) u_clamp (
    .code_i (signed'(res_code_i)),
    .code_o (clamped)
  );

  therm_judge #(
    .CODE_W    (CODE_W),
    .SEL_W     (SEL_W),
    .DT_W      (DT_W),
    .HOT_BASE  (HOT_BASE),
    .COLD_BASE (COLD_BASE),
    .DT_BASE   (DT_BASE)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_i     (wake_i),
    .accept_i   (accept),
    .sample_i   (clamped),
    .hot_sel_i  (hot_sel_i),
    .cold_sel_i (cold_sel_i),
    .dt_sel_i   (dt_sel_i),
    .value_o    (temp_value_o),
    .hot_o      (hot),
    .cold_o     (cold),
    .chg_o      (chg)
  );

  always_comb begin
    set_v = '0;
    if (accept) begin
      set_v.eoc  = 1'b1;
      set_v.hot  = hot;
      set_v.cold = cold;
      set_v.chg  = chg;
    end
  end

  therm_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .wake_i (wake_i),
    .set_i  (set_v),
    .clr_i  (flag_clr_i),
    .flag_o (flags_o)
  );

  assign start_bit_o = busy;
  assign conv_done_o = !busy;

endmodule

// File: rtl/therm_watch_chk.sv
module therm_watch_chk #(
  parameter int CODE_W   = 8,
  parameter int LO_LIMIT = -10,
  parameter int HI_LIMIT = 85
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_i,
  input logic              start_i,
  input logic              adc_start_o,
  input logic              res_valid_i,
  input logic              res_ready_o,
  input logic              start_bit_o,
  input logic              conv_done_o,
  input logic [CODE_W-1:0] temp_value_o,
  input logic [3:0]        flags_o
);

  localparam logic signed [CODE_W-1:0] LO_C = CODE_W'(LO_LIMIT);
  localparam logic signed [CODE_W-1:0] HI_C = CODE_W'(HI_LIMIT);

  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i && start_i && !start_bit_o |=> adc_start_o && start_bit_o && !conv_done_o);

  assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i && res_valid_i && res_ready_o |=> !start_bit_o && conv_done_o);

  assert_no_relaunch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit_o |=> !adc_start_o);

  assert_idle_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_bit_o |-> !res_ready_o);

  assert_value_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i && !(res_valid_i && res_ready_o) |=> $stable(temp_value_o));

  assert_eoc_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i && res_valid_i && res_ready_o |=> flags_o[0]);

  assert_value_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(temp_value_o) >= LO_C) && ($signed(temp_value_o) <= HI_C));

  assert_sleep_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_i |=> !start_bit_o && (flags_o == 4'b0) && (temp_value_o == '0));

endmodule

bind therm_watch therm_watch_chk #(
  .CODE_W   (CODE_W),
  .LO_LIMIT (LO_LIMIT),
  .HI_LIMIT (HI_LIMIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake_i       (wake_i),
  .start_i      (start_i),
  .adc_start_o  (adc_start_o),
  .res_valid_i  (res_valid_i),
  .res_ready_o  (res_ready_o),
  .start_bit_o  (start_bit_o),
  .conv_done_o  (conv_done_o),
  .temp_value_o (temp_value_o),
  .flags_o      (flags_o)
);

// File: tb/therm_watch_tb.sv
module therm_watch_tb;

  logic       clk = 1'b0;
  logic       rst_n, wake_i, start_i, res_valid_i;
  logic [7:0] res_code_i;
  logic [1:0] dt_sel_i;
  logic [3:0] hot_sel_i, cold_sel_i, flag_clr_i;
  logic       adc_start_o, res_ready_o, start_bit_o, conv_done_o;
  logic [7:0] temp_value_o;
  logic [3:0] flags_o;

  int total = 0;
  int bad   = 0;
  int bvld  = 0;
  int bval  = 0;

  always #2.5 clk = ~clk;

  therm_watch u_dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .start_i(start_i),
    .adc_start_o(adc_start_o), .res_valid_i(res_valid_i), .res_ready_o(res_ready_o),
    .res_code_i(res_code_i), .dt_sel_i(dt_sel_i), .hot_sel_i(hot_sel_i),
    .cold_sel_i(cold_sel_i), .flag_clr_i(flag_clr_i), .start_bit_o(start_bit_o),
    .conv_done_o(conv_done_o), .temp_value_o(temp_value_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampv(input logic [7:0] code);
    int v = int'($signed(code));
    if (v < -10) return -10;
    if (v > 85) return 85;
    return v;
  endfunction

  // Full acquisition; checks R1/R2/R3/R5..R10, optional same-edge clear (R11).
  task automatic conv(input logic [7:0] code, input bit poke, input bit clr_same);
    int s, d, exp_chg;
    @(negedge clk);
    start_i = 1'b1; flag_clr_i = 4'hF;
    @(negedge clk);
    start_i = 1'b0; flag_clr_i = 4'h0;
    chk("R1", "start bit", int'(start_bit_o), 1);
    chk("R1", "conv done", int'(conv_done_o), 0);
    chk("R1", "adc start", int'(adc_start_o), 1);
    res_valid_i = 1'b1; res_code_i = code; start_i = poke;
    flag_clr_i = clr_same ? 4'hF : 4'h0;
    @(negedge clk);
    res_valid_i = 1'b0; start_i = 1'b0; flag_clr_i = 4'h0;
    s = clampv(code);
    exp_chg = 0;
    if (bvld == 0) begin
      bvld = 1; bval = s;
    end else begin
      d = (s > bval) ? s - bval : bval - s;
      if (d >= 2 + int'(dt_sel_i)) begin exp_chg = 1; bval = s; end
    end
    chk("R2", "start bit cleared", int'(start_bit_o), 0);
    chk("R2", "conv done", int'(conv_done_o), 1);
    chk("R3", "no second pulse", int'(adc_start_o), 0);
    chk("R6", "value", int'($signed(temp_value_o)), s);
    chk("R5", "eoc", int'(flags_o[0]), 1);
    chk("R7", "hot", int'(flags_o[1]), int'(s >= 42 + int'(hot_sel_i)));
    chk("R8", "cold", int'(flags_o[2]), int'(s <= -7 + int'(cold_sel_i)));
    chk("R10", "change", int'(flags_o[3]), exp_chg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] keep;
    logic [7:0] held;
    rst_n = 1'b0; wake_i = 1'b1; start_i = 1'b0; res_valid_i = 1'b0;
    res_code_i = 8'h00; dt_sel_i = 2'd0; hot_sel_i = 4'd0; cold_sel_i = 4'd0;
    flag_clr_i = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset conv done", int'(conv_done_o), 1);
    chk("R2", "reset start bit", int'(start_bit_o), 0);
    chk("R12", "reset value", int'(temp_value_o), 0);
    chk("R12", "reset flags", int'(flags_o), 0);
    chk("R4", "reset ready", int'(res_ready_o), 0);

    // R9: first reading after reset sets baseline, no change even far from 0
    conv(8'd60, 1'b0, 1'b0);
    chk("R9", "first reading no change", int'(flags_o[3]), 0);

    // Sweep every code under every change threshold; thresholds rotate.
    for (int dt = 0; dt < 4; dt++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] c = 8'((i * 37 + dt * 11) & 255);
        dt_sel_i   = 2'(dt);
        hot_sel_i  = 4'((i + dt) & 15);
        cold_sel_i = 4'((i * 3 + dt) & 15);
        conv(c, c[0], c[1]);
      end
    end

    // Small-step walk around the change threshold (R10 keep/replace baseline)
    for (int dt = 0; dt < 4; dt++) begin
      dt_sel_i = 2'(dt);
      for (int i = 0; i < 40; i++) begin
        conv(8'(20 + (i * 3) % 13), 1'b0, 1'b0);
      end
    end

    // R4: result offered while idle is not consumed
    held = temp_value_o;
    @(negedge clk); flag_clr_i = 4'hF;
    @(negedge clk); flag_clr_i = 4'h0;
    res_valid_i = 1'b1; res_code_i = 8'h50;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4", "ready while idle", int'(res_ready_o), 0);
      chk("R4", "value held", int'(temp_value_o), int'(held));
      chk("R4", "flags held", int'(flags_o), 0);
    end
    res_valid_i = 1'b0;

    // R11: per-bit clear keeps other flags
    hot_sel_i = 4'd0; cold_sel_i = 4'd15; dt_sel_i = 2'd0;
    conv(8'd5, 1'b0, 1'b0);
    keep = flags_o;
    chk("R11", "cold set before clear", int'(flags_o[2]), 1);
    @(negedge clk); flag_clr_i = 4'b0001;
    @(negedge clk); flag_clr_i = 4'h0;
    chk("R11", "eoc cleared only", int'(flags_o), int'(keep & 4'b1110));
    @(negedge clk); flag_clr_i = 4'b0100;
    @(negedge clk); flag_clr_i = 4'h0;
    chk("R11", "cold cleared", int'(flags_o), int'(keep & 4'b1010));

    // R12: wakeup low mid-acquisition empties block, start ignored while low
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R1", "busy before sleep", int'(start_bit_o), 1);
    wake_i = 1'b0;
    @(negedge clk);
    chk("R12", "sleep start bit", int'(start_bit_o), 0);
    chk("R12", "sleep conv done", int'(conv_done_o), 1);
    chk("R12", "sleep flags", int'(flags_o), 0);
    chk("R12", "sleep value", int'(temp_value_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R12", "start ignored asleep", int'(adc_start_o), 0);
    chk("R12", "no acquisition asleep", int'(start_bit_o), 0);
    wake_i = 1'b1;
    bvld = 0;
    @(negedge clk);
    conv(8'hA0, 1'b0, 1'b0);
    chk("R9", "first after wake no change", int'(flags_o[3]), 0);
    chk("R6", "low clamp 0xF6", int'(temp_value_o), 8'hF6);
    conv(8'h7F, 1'b0, 1'b0);
    chk("R6", "high clamp 0x55", int'(temp_value_o), 8'h55);
    chk("R10", "large move flags", int'(flags_o[3]), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule